// File: doc/BRIEF.md
# Dual-Register Serial-to-Parallel Latch

This block turns a serial bit stream into a parallel word. It does so with two registers of equal width. A shift register takes one bit from the serial input on each rising edge of its own clock. The new bit enters the lowest stage and every older bit moves one stage up. A storage register copies the whole shift word on each rising edge of a separate storage clock, and only the storage register drives the parallel outputs. This lets a host stream a new word in while the outputs keep showing the last word it committed.

Each register has its own active-low asynchronous clear, and that clear wins over its clock. The top stage of the shift register is also brought out as a cascade output. Feeding that output into the serial input of a second instance builds a wider chain that shares clocks and clears. If both clocks are tied to one signal, the storage register captures the shift word as it stood before the edge, so it trails the shift register by one pulse.

Top module: `sipo_dual_latch`

## Requirements
- R1: After both clears are asserted, every parallel output and the cascade output read 0.
- R2: A rising shift-clock edge loads `ser_in` into stage 0 (parallel bit 0) and moves stage i to stage i+1. The old top stage is lost.
- R3: `ser_in` is sampled only at a rising shift-clock edge. Changing it between edges alters neither the cascade output nor any word captured later.
- R4: `par_out` changes only on a rising storage-clock edge or a storage clear. Shift edges alone leave it unchanged.
- R5: `cascade_out` always equals the top shift stage. Chaining two instances through it behaves as one shift register of twice the width, with the low instance holding bits 0 to WIDTH-1.
- R6: A low `shift_clr_n` zeroes the shift register at once and holds it at zero through shift edges. It leaves `par_out` unchanged.
- R7: A low `store_clr_n` zeroes `par_out` at once and holds it at zero through storage edges. It leaves the shift word and `cascade_out` unchanged.
- R8: When both clocks rise together, the storage register captures the shift word from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data bit entering stage 0 |
| shift_clk | input | 1 | Shift register clock, rising edge |
| store_clk | input | 1 | Storage register clock, rising edge |
| shift_clr_n | input | 1 | Asynchronous clear of the shift register, active low |
| store_clr_n | input | 1 | Asynchronous clear of the storage register, active low |
| par_out | output | WIDTH | Storage register contents |
| cascade_out | output | 1 | Top shift stage, feeds the next instance in a chain |

## Verification
A wrong bit in the shift register has two ways to reach the ports. It shows on `par_out` at the next storage edge. It also reaches `cascade_out` once it has climbed to the top stage, which takes at most WIDTH shift edges, or one more instance width in a chain. A corrupted storage bit shows on `par_out` straight away and stays there until the next storage edge or storage clear. The bench compares the parallel and cascade outputs of a two-instance chain against a 16-bit model after every operation, so most faults show up within one operation of their cause. Clears that cross between the two registers are checked by committing a word after the clear and comparing it with the model.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
   // smallest legal register width: a shift path needs at least two stages
   localparam int MIN_WIDTH = 2;
   // clear level that empties a register
   localparam logic CLR_ACTIVE = 1'b0;
endpackage

// File: rtl/sdl_bit_ff.sv
module sdl_bit_ff (
   input  logic clk,
   input  logic clr_n,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or negedge clr_n) begin
      if (clr_n == sdl_pkg::CLR_ACTIVE) q <= 1'b0;
      else                              q <= d;
   end
endmodule

// File: rtl/sdl_shift_chain.sv
module sdl_shift_chain #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             din,
   output logic [WIDTH-1:0] stages
);
   logic [WIDTH-1:0] next_d;

   // stage 0 takes the serial bit, stage i takes stage i-1
   assign next_d = {stages[WIDTH-2:0], din};

   for (genvar g = 0; g < WIDTH; g++) begin : g_stage
      sdl_bit_ff u_ff (
         .clk   (clk),
         .clr_n (clr_n),
         .d     (next_d[g]),
         .q     (stages[g])
      );
   end
endmodule

// File: rtl/sdl_hold_reg.sv
module sdl_hold_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      sdl_bit_ff u_ff (
         .clk   (clk),
         .clr_n (clr_n),
         .d     (d[g]),
         .q     (q[g])
      );
   end
endmodule

// File: rtl/sipo_dual_latch.sv
module sipo_dual_latch #(
   parameter int WIDTH = 8
) (
   input  logic             ser_in,
   input  logic             shift_clk,
   input  logic             store_clk,
   input  logic             shift_clr_n,
   input  logic             store_clr_n,
   output logic [WIDTH-1:0] par_out,
   output logic             cascade_out
);
   localparam int TOP = WIDTH - 1;

   if (WIDTH < sdl_pkg::MIN_WIDTH) begin : g_bad_width
      $error("sipo_dual_latch: WIDTH must be at least %0d", sdl_pkg::MIN_WIDTH);
   end

   logic [WIDTH-1:0] shift_q;

   sdl_shift_chain #(.WIDTH(WIDTH)) u_chain (
      .clk    (shift_clk),
      .clr_n  (shift_clr_n),
      .din    (ser_in),
      .stages (shift_q)
   );

   sdl_hold_reg #(.WIDTH(WIDTH)) u_hold (
      .clk   (store_clk),
      .clr_n (store_clr_n),
      .d     (shift_q),
      .q     (par_out)
   );

   assign cascade_out = shift_q[TOP];
endmodule

// File: rtl/sdl_checker.sv
module sdl_checker #(
   parameter int WIDTH = 8
) (
   input logic             ser_in,
   input logic             shift_clk,
   input logic             store_clk,
   input logic             shift_clr_n,
   input logic             store_clr_n,
   input logic [WIDTH-1:0] par_out,
   input logic             cascade_out,
   input logic [WIDTH-1:0] shift_q
);
   // set by a clear, dropped by the next clean edge: marks $past as unusable
   logic sh_dirty, st_dirty;

   always_ff @(posedge shift_clk or negedge shift_clr_n) begin
      if (!shift_clr_n) sh_dirty <= 1'b1;
      else              sh_dirty <= 1'b0;
   end

   always_ff @(posedge store_clk or negedge store_clr_n) begin
      if (!store_clr_n) st_dirty <= 1'b1;
      else              st_dirty <= 1'b0;
   end

   // R2, R3: each shift edge moved the word up one place and took ser_in
   a_r2_shift_step: assert property (@(posedge shift_clk) disable iff (!shift_clr_n)
      !sh_dirty |-> shift_q == {$past(shift_q[WIDTH-2:0]), $past(ser_in)});

   // R4, R8: the storage word equals the shift word seen at the previous storage edge
   a_r4_capture: assert property (@(posedge store_clk) disable iff (!store_clr_n)
      !st_dirty |-> par_out == $past(shift_q));

   // R6: a held shift clear keeps the shift word empty through shift edges
   a_r6_shift_clear: assert property (@(posedge shift_clk)
      (!shift_clr_n && !$past(shift_clr_n)) |-> (shift_q == '0 && cascade_out == 1'b0));

   // R7: a held storage clear keeps the outputs empty through storage edges
   a_r7_store_clear: assert property (@(posedge store_clk)
      (!store_clr_n && !$past(store_clr_n)) |-> par_out == '0);
endmodule

bind sipo_dual_latch sdl_checker #(.WIDTH(WIDTH)) u_sdl_chk (
   .ser_in      (ser_in),
   .shift_clk   (shift_clk),
   .store_clk   (store_clk),
   .shift_clr_n (shift_clr_n),
   .store_clr_n (store_clr_n),
   .par_out     (par_out),
   .cascade_out (cascade_out),
   .shift_q     (shift_q)
);

// File: tb/sipo_dual_latch_tb_top.sv
`timescale 1ns/1ps
module sipo_dual_latch_tb_top;
   localparam int W = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic ser_in = 1'b0, shift_clk = 1'b0, store_clk = 1'b0;
   logic shift_clr_n = 1'b1, store_clr_n = 1'b1;
   logic [W-1:0] par_lo, par_hi;
   logic casc_lo, casc_hi;

   sipo_dual_latch #(.WIDTH(W)) dut_i (
      .ser_in(ser_in), .shift_clk(shift_clk), .store_clk(store_clk),
      .shift_clr_n(shift_clr_n), .store_clr_n(store_clr_n),
      .par_out(par_lo), .cascade_out(casc_lo));

   sipo_dual_latch #(.WIDTH(W)) dut_hi_i (
      .ser_in(casc_lo), .shift_clk(shift_clk), .store_clk(store_clk),
      .shift_clr_n(shift_clr_n), .store_clr_n(store_clr_n),
      .par_out(par_hi), .cascade_out(casc_hi));

   logic [15:0] m_sh = '0, m_st = '0;
   int n_chk = 0, n_bad = 0;
   int cyc = 0;
   bit done = 0;

   function automatic logic [15:0] shifted(logic [15:0] v, logic b);
      return {v[14:0], b};
   endfunction

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_all(string req);
      #1;
      chk({req, " par"}, {par_hi, par_lo}, m_st);
      chk({req, " cascade"}, {14'd0, casc_hi, casc_lo}, {14'd0, m_sh[15], m_sh[7]});
   endtask

   task automatic do_shift(logic b);
      ser_in = b; #3;
      shift_clk = 1'b1; #5;
      shift_clk = 1'b0; #2;
      if (shift_clr_n) m_sh = shifted(m_sh, b);
   endtask

   task automatic do_store();
      #3; store_clk = 1'b1; #5; store_clk = 1'b0; #2;
      if (store_clr_n) m_st = m_sh;
   endtask

   task automatic do_both(logic b);
      ser_in = b; #3;
      shift_clk = 1'b1; store_clk = 1'b1; #5;
      shift_clk = 1'b0; store_clk = 1'b0; #2;
      if (store_clr_n) m_st = m_sh;
      if (shift_clr_n) m_sh = shifted(m_sh, b);
   endtask

   task automatic pulse_shift_clear();
      shift_clr_n = 1'b0; m_sh = '0; #4;
      chk_all("R6 shift clear");
      shift_clr_n = 1'b1; #4;
   endtask

   task automatic pulse_store_clear();
      store_clr_n = 1'b0; m_st = '0; #4;
      chk_all("R7 store clear");
      store_clr_n = 1'b1; #4;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0594));
      #5;
      shift_clr_n = 1'b0; store_clr_n = 1'b0; #5;
      chk_all("R1 clear state");
      // R6, R7: a held clear overrides clock edges
      do_shift(1'b1); do_store();
      chk_all("R6 R7 clear beats clock");
      shift_clr_n = 1'b1; store_clr_n = 1'b1; #5;

      // R2: single one enters bit 0, moves up one per edge
      do_shift(1'b1); do_store();
      chk_all("R2 entry at bit 0");
      do_shift(1'b0); do_shift(1'b0); do_store();
      chk_all("R2 moved up");

      // R4: shifts without a storage edge leave par_out alone
      do_shift(1'b1); do_shift(1'b1);
      chk_all("R4 par holds during shift");

      // R3: ser_in wiggles without an edge are ignored
      ser_in = 1'b1; #4; ser_in = 1'b0; #4; ser_in = 1'b1; #4;
      do_store();
      chk_all("R3 ser ignored between edges");

      // R5: walk a 16-bit pattern through the chain
      for (int i = 15; i >= 0; i--) begin
         logic [15:0] pat = 16'hA5C3;
         do_shift(pat[i]);
      end
      do_store();
      chk("R5 chained 16-bit word", {par_hi, par_lo}, 16'hA5C3);
      chk_all("R5 chain model");

      // R7 then R6 crosses: clear one side, commit, compare
      pulse_store_clear();
      do_store();
      chk_all("R7 shift word kept after store clear");
      pulse_shift_clear();
      chk_all("R6 par kept after shift clear");
      do_store();
      chk_all("R6 committed zero word");

      // R8: tied clocks capture the pre-edge word
      do_shift(1'b1); do_shift(1'b0); do_shift(1'b1);
      do_both(1'b1);
      chk_all("R8 tied clocks one behind");
      do_both(1'b0);
      chk_all("R8 tied clocks second pulse");

      // mixed random operations
      for (int k = 0; k < 400; k++) begin
         int op = $urandom % 16;
         logic b = 1'($urandom);
         if      (op < 8)   do_shift(b);
         else if (op < 11)  do_store();
         else if (op < 13)  do_both(b);
         else if (op == 13) pulse_shift_clear();
         else if (op == 14) pulse_store_clear();
         else begin ser_in = ~ser_in; #4; end
         chk_all("R2 R4 R5 R8 random mix");
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule